// File: doc/BRIEF.md
# Periodic Interrupt Down-Counter

This block produces a periodic interrupt from a 16-bit down-counter. A power-of-two prescaler divides the clock, and each prescaler terminal tick moves the counter down by one. If a tick arrives while the counter holds zero, the counter reloads from a modulus register and a sticky flag sets. Software can route that flag to a registered interrupt output, clear it, and read the live count at any time.

Software controls the block through a small synchronous register port with write enable, address, write data and registered read data. Address 0 holds control and status, address 1 holds the modulus, and address 2 returns the live count. An overwrite option makes a modulus write load the counter at once. A separate option for low-power and one for halt each let a chip-level input freeze the count. Register access keeps working while the count is frozen.

Top module: `interval_timer`

## Requirements
- R1: After reset the control word reads 0x0000, the modulus and the count both read 0xFFFF, and `irq_o` is low.
- R2: The control word at address 0 has run enable at bit 0, the flag at bit 2, interrupt enable at bit 3, overwrite at bit 4, halt-freeze at bit 5, doze-freeze at bit 6 and the prescale select at bits 11:8. All other bits read 0. Address 1 is the modulus. Address 2 reads the count, and writes to it are ignored. Address 3 reads 0. `rdata` shows the addressed register one cycle after `addr` is presented.
- R3: While run enable is 1 and no freeze applies, the count falls by one every 2^select clocks (select 0 gives every clock, 15 gives every 32768). With run enable at 0 the count and the prescaler hold.
- R4: The prescaler restarts from zero on reset, on a control write that changes the select value, and whenever the counter is loaded by a reload or an overwrite.
- R5: A tick with the count at 0x0000 loads the modulus into the counter and sets the flag.
- R6: With overwrite at 0, a modulus write leaves the count unchanged. With overwrite at 1, the written value replaces the count on the next cycle.
- R7: Writing 1 to the flag bit clears the flag, and any modulus write clears it too. Writing 0 to the flag bit leaves it unchanged. If a flag set and a clear fall in the same cycle, the set wins.
- R8: `irq_o` equals flag AND interrupt enable, delayed by one register stage.
- R9: With doze-freeze at 1, a high `doze_i` holds the count and the prescaler, and counting resumes from that state once `doze_i` falls. With doze-freeze at 0, `doze_i` has no effect.
- R10: With halt-freeze at 1, a high `debug_i` holds the count. Clearing halt-freeze while `debug_i` is high restarts counting, and setting it again stops counting. Register writes made during the freeze are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| doze_i | input | 1 | Low-power state indication |
| debug_i | input | 1 | Halted/debug state indication |
| irq_o | output | 1 | Registered interrupt request |

## Verification
Two situations are hard to reach from the ports. The first is a flag clear that falls in exactly the cycle the flag sets. The bench forces it by loading a modulus of zero with overwrite on, so that every clock wraps, and then writing a clear. The second is a prescaler restart in the middle of a period, which shows up only in one cycle of a count readout. The bench places its reads at cycle-exact offsets after the select change. A cycle-level reference model also follows seeded random writes, freeze toggles and prescale values, and compares every read and interrupt.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int ADDR_W = 2;
  localparam int PRE_W  = 4;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_MOD  = 2'd1;
  localparam logic [ADDR_W-1:0] A_CNT  = 2'd2;

  localparam int B_EN     = 0;
  localparam int B_FLAG   = 2;
  localparam int B_IE     = 3;
  localparam int B_OVW    = 4;
  localparam int B_DBG    = 5;
  localparam int B_DOZE   = 6;
  localparam int B_PRE_LO = 8;

  typedef struct packed {
    logic [PRE_W-1:0] pre;
    logic             doze_frz;
    logic             dbg_frz;
    logic             ovw;
    logic             ie;
    logic             en;
  } ctrl_t;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int DIV_W = (1 << SEL_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] term;

  // terminal value 2^sel - 1 as a thermometer code
  for (genvar i = 0; i < DIV_W; i++) begin : g_term
    assign term[i] = (sel > SEL_W'(i));
  end

  assign tick = run && (div_q == term);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      div_q <= '0;
    end else if (run) begin
      div_q <= tick ? '0 : div_q + DIV_W'(1);
    end
  end
endmodule

// File: rtl/tmr_downcount.sv
module tmr_downcount #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         force_ld,
  input  logic [W-1:0] force_val,
  input  logic [W-1:0] reload_val,
  output logic [W-1:0] cnt,
  output logic         wrap,
  output logic         loaded
);
  assign wrap   = tick && (cnt == '0);
  assign loaded = wrap || force_ld;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '1;
    end else if (force_ld) begin
      cnt <= force_val;
    end else if (wrap) begin
      cnt <= reload_val;
    end else if (tick) begin
      cnt <= cnt - W'(1);
    end
  end
endmodule

// File: rtl/tmr_ctrl_regs.sv
module tmr_ctrl_regs
  import timer_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  input  logic              flag_set,
  output ctrl_t             ctrl,
  output logic [W-1:0]      mod,
  output logic              flag,
  output logic              mod_wr,
  output logic              pre_chg
);
  logic ctl_wr;
  logic unused_bits;

  assign ctl_wr  = wr_en && (addr == A_CTRL);
  assign mod_wr  = wr_en && (addr == A_MOD);
  assign pre_chg = ctl_wr && (wdata[B_PRE_LO +: PRE_W] != ctrl.pre);
  assign unused_bits = ^{wdata[W-1:B_PRE_LO+PRE_W], wdata[7], wdata[1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
      mod  <= '1;
      flag <= 1'b0;
    end else begin
      if (ctl_wr) begin
        ctrl.en       <= wdata[B_EN];
        ctrl.ie       <= wdata[B_IE];
        ctrl.ovw      <= wdata[B_OVW];
        ctrl.dbg_frz  <= wdata[B_DBG];
        ctrl.doze_frz <= wdata[B_DOZE];
        ctrl.pre      <= wdata[B_PRE_LO +: PRE_W];
      end
      if (mod_wr) begin
        mod <= wdata;
      end
      if (flag_set) begin
        flag <= 1'b1;
      end else if (mod_wr || (ctl_wr && wdata[B_FLAG])) begin
        flag <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  input  logic              doze_i,
  input  logic              debug_i,
  output logic              irq_o
);
  ctrl_t             ctrl;
  logic [CNT_W-1:0]  mod_w;
  logic [CNT_W-1:0]  cnt_w;
  logic [CNT_W-1:0]  ctrl_word;
  logic              flag_w, mod_wr, pre_chg;
  logic              en_w, ie_w, ovw_w, dbg_frz_w, doze_frz_w;
  logic              run, tick, wrap, loaded, force_ld;

  assign en_w       = ctrl.en;
  assign ie_w       = ctrl.ie;
  assign ovw_w      = ctrl.ovw;
  assign dbg_frz_w  = ctrl.dbg_frz;
  assign doze_frz_w = ctrl.doze_frz;

  assign run      = en_w && !(doze_frz_w && doze_i) && !(dbg_frz_w && debug_i);
  assign force_ld = mod_wr && ovw_w;

  tmr_ctrl_regs #(.W(CNT_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .flag_set (wrap),
    .ctrl     (ctrl),
    .mod      (mod_w),
    .flag     (flag_w),
    .mod_wr   (mod_wr),
    .pre_chg  (pre_chg)
  );

  tmr_prescaler #(.SEL_W(PRE_W)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .restart (pre_chg || loaded),
    .sel     (ctrl.pre),
    .tick    (tick)
  );

  tmr_downcount #(.W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .force_ld   (force_ld),
    .force_val  (wdata),
    .reload_val (mod_w),
    .cnt        (cnt_w),
    .wrap       (wrap),
    .loaded     (loaded)
  );

  always_comb begin
    ctrl_word                       = '0;
    ctrl_word[B_EN]                 = en_w;
    ctrl_word[B_FLAG]               = flag_w;
    ctrl_word[B_IE]                 = ie_w;
    ctrl_word[B_OVW]                = ovw_w;
    ctrl_word[B_DBG]                = dbg_frz_w;
    ctrl_word[B_DOZE]               = doze_frz_w;
    ctrl_word[B_PRE_LO +: PRE_W]    = ctrl.pre;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      irq_o <= 1'b0;
    end else begin
      irq_o <= flag_w && ie_w;
      case (addr)
        A_CTRL:  rdata <= ctrl_word;
        A_MOD:   rdata <= mod_w;
        A_CNT:   rdata <= cnt_w;
        default: rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         tick,
  input logic         wrap,
  input logic [W-1:0] cnt,
  input logic [W-1:0] mod,
  input logic [W-1:0] wdata,
  input logic         mod_wr,
  input logic         flag,
  input logic         ie,
  input logic         en,
  input logic         ovw,
  input logic         doze_frz,
  input logic         doze_i,
  input logic         dbg_frz,
  input logic         debug_i,
  input logic         irq_o
);
  AST_OFF_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!en && !mod_wr) |=> $stable(cnt)); // R3
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt != '0 && !(mod_wr && ovw)) |=> cnt == W'($past(cnt) - 1'b1)); // R3
  AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
    wrap |=> flag); // R5
  AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (wrap && !(mod_wr && ovw)) |=> cnt == $past(mod)); // R5
  AST_OVW_LOAD: assert property (@(posedge clk) disable iff (rst)
    (mod_wr && ovw) |=> cnt == $past(wdata)); // R6
  AST_MOD_CLEARS_FLAG: assert property (@(posedge clk) disable iff (rst)
    (mod_wr && !wrap) |=> !flag); // R7
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(ie) && $past(flag)); // R8
  AST_DOZE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (doze_frz && doze_i && !mod_wr) |=> $stable(cnt)); // R9
  AST_DEBUG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (dbg_frz && debug_i && !mod_wr) |=> $stable(cnt)); // R10
endmodule

bind interval_timer tmr_checker #(.W(CNT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .tick     (tick),
  .wrap     (wrap),
  .cnt      (cnt_w),
  .mod      (mod_w),
  .wdata    (wdata),
  .mod_wr   (mod_wr),
  .flag     (flag_w),
  .ie       (ie_w),
  .en       (en_w),
  .ovw      (ovw_w),
  .doze_frz (doze_frz_w),
  .doze_i   (doze_i),
  .dbg_frz  (dbg_frz_w),
  .debug_i  (debug_i),
  .irq_o    (irq_o)
);

// File: tb/interval_timer_test.sv
module interval_timer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = 16'h0;
  logic [15:0] rdata;
  logic        doze_i = 1'b0;
  logic        debug_i = 1'b0;
  logic        irq_o;

  int n_tests = 0;
  int n_fail  = 0;

  interval_timer uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .doze_i(doze_i), .debug_i(debug_i), .irq_o(irq_o)
  );

  always #4 clk = ~clk;

  // reference state
  logic        m_en, m_ie, m_ovw, m_db, m_dz, m_flag, m_irq;
  logic [3:0]  m_pre;
  logic [14:0] m_pc;
  logic [15:0] m_mod, m_cnt, m_rd;

  function automatic logic [14:0] term_of(input logic [3:0] p);
    return (15'(1) << p) - 15'(1);
  endfunction

  function automatic logic [15:0] exp_ctrl(input logic en, fl, ie, ov, db, dz,
                                           input logic [3:0] p);
    return {4'h0, p, 1'b0, dz, db, ov, ie, fl, 1'b0, en};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [15:0] act,
                       input logic [15:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin : ref_model
    logic run, tk, wrp, ldd, wctl, wmod, nflag;
    logic [15:0] ncnt;
    logic [14:0] npc;
    if (rst) begin
      {m_en, m_ie, m_ovw, m_db, m_dz, m_flag, m_irq} <= '0;
      m_pre <= '0; m_pc <= '0; m_mod <= 16'hFFFF; m_cnt <= 16'hFFFF; m_rd <= '0;
    end else begin
      run  = m_en && !(m_dz && doze_i) && !(m_db && debug_i);
      tk   = run && (m_pc == term_of(m_pre));
      wctl = wr_en && addr == 2'd0;
      wmod = wr_en && addr == 2'd1;
      wrp  = tk && m_cnt == 16'h0;
      ldd  = wrp;
      ncnt = m_cnt;
      if (tk) ncnt = wrp ? m_mod : m_cnt - 16'd1;
      if (wmod && m_ovw) begin ncnt = wdata; ldd = 1'b1; end
      npc = m_pc;
      if (run) npc = tk ? 15'd0 : m_pc + 15'd1;
      if (ldd || (wctl && wdata[11:8] != m_pre)) npc = 15'd0;
      nflag = m_flag;
      if (wmod || (wctl && wdata[2])) nflag = 1'b0;
      if (wrp) nflag = 1'b1;
      case (addr)
        2'd0: m_rd <= exp_ctrl(m_en, m_flag, m_ie, m_ovw, m_db, m_dz, m_pre);
        2'd1: m_rd <= m_mod;
        2'd2: m_rd <= m_cnt;
        default: m_rd <= 16'h0;
      endcase
      m_irq <= m_flag && m_ie;
      m_cnt <= ncnt; m_pc <= npc; m_flag <= nflag;
      if (wmod) m_mod <= wdata;
      if (wctl) begin
        m_en <= wdata[0]; m_ie <= wdata[3]; m_ovw <= wdata[4];
        m_db <= wdata[5]; m_dz <= wdata[6]; m_pre <= wdata[11:8];
      end
    end
  end

  // every cycle: read data and interrupt against the model (R2, R3, R4, R5, R8)
  always @(negedge clk) begin
    if (!rst) begin
      check(rdata === m_rd, "R2 model rdata", rdata, m_rd);
      check(irq_o === m_irq, "R8 model irq", {15'h0, irq_o}, {15'h0, m_irq});
    end
  end

  // tasks start and end just after a falling edge
  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    addr = a;
    @(negedge clk);
    v = rdata;
  endtask

  task automatic wait_irq(output bit got);
    got = 1'b0;
    for (int i = 0; i < 64 && !got; i++) begin
      @(negedge clk);
      got = irq_o;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : stim
    logic [15:0] v, v2, v3;
    bit got;
    void'($urandom(32'd20240611));
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    check(irq_o === 1'b0, "R1 irq after reset", {15'h0, irq_o}, 16'h0);
    rd(2'd0, v); check(v === 16'h0000, "R1 ctrl reset", v, 16'h0000);
    rd(2'd1, v); check(v === 16'hFFFF, "R1 modulus reset", v, 16'hFFFF);
    rd(2'd2, v); check(v === 16'hFFFF, "R1 count reset", v, 16'hFFFF);

    // R2: reserved bits read 0, flag bit not settable, count read-only
    wr(2'd0, 16'hF07E);
    rd(2'd0, v); check(v === 16'h0078, "R2 ctrl readback", v, 16'h0078);
    wr(2'd2, 16'h1234);
    rd(2'd2, v); check(v === 16'hFFFF, "R2 count write ignored", v, 16'hFFFF);
    rd(2'd3, v); check(v === 16'h0000, "R2 unused address", v, 16'h0000);

    // R6: overwrite on, then off
    wr(2'd1, 16'h0005);
    rd(2'd2, v); check(v === 16'h0005, "R6 overwrite loads count", v, 16'h0005);
    wr(2'd0, 16'h0000);
    wr(2'd1, 16'h0009);
    rd(2'd2, v); check(v === 16'h0005, "R6 no overwrite keeps count", v, 16'h0005);

    // R9: doze freeze, then resume
    doze_i = 1'b1;
    wr(2'd0, 16'h0041);
    rd(2'd2, v);
    repeat (20) @(negedge clk);
    rd(2'd2, v2); check(v2 === v, "R9 doze holds count", v2, v);
    doze_i = 1'b0;
    repeat (5) @(negedge clk);
    rd(2'd2, v3); check(v3 !== v2, "R9 resumes after doze", v3, v2);
    // R9: doze ignored when the freeze bit is 0
    wr(2'd0, 16'h0001);
    doze_i = 1'b1;
    rd(2'd2, v); rd(2'd2, v2);
    check(v2 !== v, "R9 doze ignored when bit clear", v2, v);
    doze_i = 1'b0;

    // R10: halt freeze and toggling the bit while halted
    debug_i = 1'b1;
    wr(2'd0, 16'h0021);
    rd(2'd2, v); rd(2'd2, v2);
    check(v2 === v, "R10 debug holds count", v2, v);
    wr(2'd0, 16'h0001);
    rd(2'd2, v); rd(2'd2, v2);
    check(v2 !== v, "R10 clearing bit restarts", v2, v);
    wr(2'd0, 16'h0021);
    wr(2'd1, 16'h0007);
    rd(2'd2, v); rd(2'd2, v2);
    check(v2 === v, "R10 setting bit stops", v2, v);
    rd(2'd1, v); check(v === 16'h0007, "R10 write kept during freeze", v, 16'h0007);
    debug_i = 1'b0;

    // R5, R8: flag raises the interrupt
    wr(2'd0, 16'h0009);
    wait_irq(got);
    check(got, "R5 wrap sets flag and irq", {15'h0, got}, 16'h1);
    wr(2'd0, 16'h0008);
    rd(2'd0, v); check(v === 16'h000C, "R7 writing 0 keeps flag", v, 16'h000C);
    wr(2'd0, 16'h0000);
    @(negedge clk);
    check(irq_o === 1'b0, "R8 irq masked", {15'h0, irq_o}, 16'h0);
    wr(2'd0, 16'h0008);
    @(negedge clk);
    check(irq_o === 1'b1, "R8 irq unmasked", {15'h0, irq_o}, 16'h1);
    wr(2'd0, 16'h000C);
    rd(2'd0, v); check(v === 16'h0008, "R7 write 1 clears flag", v, 16'h0008);
    wr(2'd0, 16'h0009);
    wait_irq(got);
    wr(2'd0, 16'h0008);
    wr(2'd1, 16'h0003);
    rd(2'd0, v); check(v === 16'h0008, "R7 modulus write clears flag", v, 16'h0008);

    // R7: set wins over clear (modulus 0 wraps every clock)
    wr(2'd0, 16'h0011);
    wr(2'd1, 16'h0000);
    repeat (2) @(negedge clk);
    wr(2'd0, 16'h0015);
    rd(2'd0, v); check(v === 16'h0015, "R7 set wins over clear", v, 16'h0015);
    wr(2'd0, 16'h0000);

    // R3, R4: exact prescaler timing
    wr(2'd0, 16'h0310);
    wr(2'd1, 16'd100);
    wr(2'd0, 16'h0311);
    rd(2'd2, v);  check(v === 16'd100, "R3 count before first tick", v, 16'd100);
    repeat (6) @(negedge clk);
    rd(2'd2, v2); check(v2 === 16'd100, "R3 no tick before 8 clocks", v2, 16'd100);
    rd(2'd2, v3); check(v3 === 16'd99, "R3 tick after 8 clocks", v3, 16'd99);
    wr(2'd0, 16'h0211);
    repeat (3) @(negedge clk);
    rd(2'd2, v);  check(v === 16'd99, "R4 prescaler restarted on change", v, 16'd99);
    rd(2'd2, v2); check(v2 === 16'd98, "R4 tick four clocks after change", v2, 16'd98);
    wr(2'd0, 16'h0210);
    rd(2'd2, v); repeat (10) @(negedge clk); rd(2'd2, v2);
    check(v2 === v, "R3 disabled holds", v2, v);

    // seeded random mix, checked by the per-cycle model compare
    for (int i = 0; i < 6000; i++) begin
      logic [31:0] r;
      r = $urandom;
      wr_en = (r[1:0] == 2'b00);
      addr  = r[3:2];
      case (r[3:2])
        2'd0:    wdata = (r[31:16] & 16'hF37F) | {15'h0, r[5:4] != 2'b00};
        2'd1:    wdata = r[31:16] & 16'h001F;
        default: wdata = r[31:16];
      endcase
      if (r[8:6] == 3'd0) doze_i  = ~doze_i;
      if (r[11:9] == 3'd0) debug_i = ~debug_i;
      @(negedge clk);
    end
    wr_en = 1'b0;
    @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule